// File: doc/BRIEF.md
# Dual-Destination Forwarding and Hazard Unit

This block decides, every cycle, where the two ALU operands of a five-stage integer pipeline (fetch, decode, execute, memory, writeback) take their values from. It also decides whether the instruction in decode has to wait one cycle. The pipeline includes a load that also updates its base register. That instruction writes the loaded word to its primary destination and writes base plus offset back to the base register, which is its secondary destination. Both writes commit together in writeback through a second register-file write port. Because of this, every in-flight instruction carries two destination numbers, each with its own write enable.

The two results become ready at different points. The updated base is the ALU result, so it can be forwarded from the execute/memory register one cycle later, and a reader of the base never waits. The loaded word exists only after the memory stage, so an instruction that reads it directly behind the load waits one cycle and then takes it from the memory/writeback register. A two-value forward from memory/writeback needs one more bit per operand. This "lane" bit tells the datapath which of the two writeback values to route. The block is purely combinational. The ALU, the memory, the register storage and branch handling lie outside it.

Top module: `hzd_dual_fwd_unit`

## Requirements
- R1: A source register number of 0 never produces a forward and never causes a stall, whatever the write enables and destination numbers are.
- R2: An operand selects the execute/memory register (select 2'b10, lane 0) when an enabled primary destination of a non-load, or an enabled secondary destination, in that register equals the operand's source.
- R3: The execute/memory register never supplies a register that is the enabled primary destination of a load in that stage (memory-read flag high). This includes a secondary destination that equals that primary.
- R4: Without an execute/memory forward, an operand selects the memory/writeback register (select 2'b01) when an enabled destination there matches. The lane is 0 for the primary destination and 1 for the secondary.
- R5: When both destinations in memory/writeback match the same source, the primary one wins (select 2'b01, lane 0). The loaded word is therefore the final value when a load's primary and base registers are the same.
- R6: An execute/memory forward takes priority over a memory/writeback forward for the same source.
- R7: A stall request is raised when the decode/execute register holds an enabled load primary destination, other than 0, that equals either decode source. The bubble output equals the stall request in every cycle.
- R8: A decode/execute destination that belongs to a non-load instruction never causes a stall.
- R9: With no match, an operand selects the register file (select 2'b00, lane 0). This is the idle state with all inputs at zero.
- R10: A destination whose write enable is low never matches.
- R11: The two operands are resolved independently with the same rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_src_a | input | 5 | First source register of the instruction in decode |
| id_src_b | input | 5 | Second source register of the instruction in decode |
| ex_src_a | input | 5 | First source register of the instruction in execute |
| ex_src_b | input | 5 | Second source register of the instruction in execute |
| idex_dst_p | input | 5 | Primary destination in the decode/execute register |
| idex_we_p | input | 1 | Primary write enable in the decode/execute register |
| idex_mrd | input | 1 | Memory-read flag in the decode/execute register |
| exmem_dst_p | input | 5 | Primary destination in the execute/memory register |
| exmem_we_p | input | 1 | Primary write enable in the execute/memory register |
| exmem_dst_s | input | 5 | Secondary (base update) destination in the execute/memory register |
| exmem_we_s | input | 1 | Secondary write enable in the execute/memory register |
| exmem_mrd | input | 1 | Memory-read flag in the execute/memory register |
| memwb_dst_p | input | 5 | Primary destination in the memory/writeback register |
| memwb_we_p | input | 1 | Primary write enable in the memory/writeback register |
| memwb_dst_s | input | 5 | Secondary destination in the memory/writeback register |
| memwb_we_s | input | 1 | Secondary write enable in the memory/writeback register |
| fwd_a_sel | output | 2 | Operand A source: 00 register file, 10 execute/memory, 01 memory/writeback |
| fwd_a_lane | output | 1 | Operand A memory/writeback value: 0 primary, 1 secondary |
| fwd_b_sel | output | 2 | Operand B source, same encoding as fwd_a_sel |
| fwd_b_lane | output | 1 | Operand B memory/writeback value, same encoding as fwd_a_lane |
| stall_req | output | 1 | Freeze the program counter and the fetch/decode register |
| bubble_ins | output | 1 | Insert a no-operation into the decode/execute register |

## Verification
The embedded checks hold on every evaluation for a small set of rules. A zero source never forwards and never stalls. A lane of 1 only ever comes with a memory/writeback select. A load's primary destination is never taken from the execute/memory register. A stall is only ever raised by an enabled load. The priority order, the rule that the primary destination wins when the same register is written twice, and the base-update sequence resolving with no stall can only be shown by the bench. The bench runs directed cases for these and compares a behavioural priority-scan model against many biased random pipeline states.

// File: rtl/hzd_pkg.sv
// Package: shared encodings for the dual-destination forwarding unit.
// Assumes: operand select values are decoded by the ALU input muxes.
package hzd_pkg;
    typedef enum logic [1:0] {
        FWD_RF    = 2'b00,
        FWD_MEMWB = 2'b01,
        FWD_EXMEM = 2'b10
    } fwd_src_e;

    localparam int NUM_OPS = 2;
endpackage

// File: rtl/hzd_reg_match.sv
// Module: hzd_reg_match
// Compares one source register number against one destination slot.
// Assumes: register 0 is hard-wired and never a real producer.
module hzd_reg_match #(
    parameter int RW = 5
) (
    input  logic [RW-1:0] src,
    input  logic [RW-1:0] dst,
    input  logic          we,
    output logic          hit
);
    // Hit only for an enabled, non-zero, equal register number.
    always_comb begin
        hit = we && (src != '0) && (src == dst);
    end
endmodule

// File: rtl/hzd_fwd_lane.sv
// Module: hzd_fwd_lane
// Chooses the value source for one ALU operand from two pipeline
// registers, each carrying a primary and a secondary destination.
// Assumes: the execute/memory stage holds one ALU result, which is the
// secondary value of a base-update load; a load primary in that stage is
// not yet available (the stall unit prevents that case from being needed).
module hzd_fwd_lane
    import hzd_pkg::*;
#(
    parameter int RW = 5
) (
    input  logic [RW-1:0] src,
    input  logic [RW-1:0] xm_dst_p,
    input  logic          xm_we_p,
    input  logic [RW-1:0] xm_dst_s,
    input  logic          xm_we_s,
    input  logic          xm_mrd,
    input  logic [RW-1:0] mw_dst_p,
    input  logic          mw_we_p,
    input  logic [RW-1:0] mw_dst_s,
    input  logic          mw_we_s,
    output fwd_src_e      sel,
    output logic          lane
);
    logic hit_xp, hit_xs, hit_wp, hit_ws;
    logic xm_load_shadow;
    logic xm_ok;

    hzd_reg_match #(.RW(RW)) u_m_xp (.src(src), .dst(xm_dst_p), .we(xm_we_p), .hit(hit_xp));
    hzd_reg_match #(.RW(RW)) u_m_xs (.src(src), .dst(xm_dst_s), .we(xm_we_s), .hit(hit_xs));
    hzd_reg_match #(.RW(RW)) u_m_wp (.src(src), .dst(mw_dst_p), .we(mw_we_p), .hit(hit_wp));
    hzd_reg_match #(.RW(RW)) u_m_ws (.src(src), .dst(mw_dst_s), .we(mw_we_s), .hit(hit_ws));

    // Load primary overrides a same-numbered secondary in execute/memory.
    always_comb begin
        xm_load_shadow = xm_mrd && xm_we_p && (xm_dst_p == xm_dst_s);
        xm_ok = (hit_xp && !xm_mrd) || (hit_xs && !xm_load_shadow);
    end

    // Priority pick: newest stage first, then primary before secondary.
    always_comb begin
        sel  = FWD_RF;
        lane = 1'b0;
        if (xm_ok) begin
            sel = FWD_EXMEM;
        end else if (hit_wp) begin
            sel = FWD_MEMWB;
        end else if (hit_ws) begin
            sel  = FWD_MEMWB;
            lane = 1'b1;
        end
    end

    // Guard checks on the settled select outputs.
    always_comb begin
        // R1
        zero_src_chk: assert (src != '0 || (sel == FWD_RF && !lane))
            else $error("zero source forwarded");
        // R4
        lane_stage_chk: assert (!lane || sel == FWD_MEMWB)
            else $error("lane set without writeback select");
        // R3
        no_load_early_chk: assert (!(sel == FWD_EXMEM && xm_mrd && xm_we_p && xm_dst_p == src))
            else $error("load data taken from execute/memory");
    end
endmodule

// File: rtl/hzd_load_stall.sv
// Module: hzd_load_stall
// Detects a load in execute whose primary result is needed by the
// instruction in decode, and requests a one-cycle stall.
// Assumes: only the primary destination of a load is late; the secondary
// (base update) comes from the ALU and is always forwardable.
module hzd_load_stall #(
    parameter int RW = 5
) (
    input  logic [RW-1:0] id_a,
    input  logic [RW-1:0] id_b,
    input  logic [RW-1:0] ie_dst,
    input  logic          ie_we,
    input  logic          ie_mrd,
    output logic          stall
);
    logic load_we;
    logic hit_a, hit_b;

    // Only a load's primary destination is a late producer.
    always_comb begin
        load_we = ie_we && ie_mrd;
    end

    hzd_reg_match #(.RW(RW)) u_s_a (.src(id_a), .dst(ie_dst), .we(load_we), .hit(hit_a));
    hzd_reg_match #(.RW(RW)) u_s_b (.src(id_b), .dst(ie_dst), .we(load_we), .hit(hit_b));

    // Stall if either decode source needs the late load word.
    always_comb begin
        stall = hit_a || hit_b;
    end

    // Guard checks on the stall output.
    always_comb begin
        // R8
        stall_cause_chk: assert (!stall || (ie_mrd && ie_we))
            else $error("stall without enabled load");
        // R1
        stall_zero_chk: assert (!stall || ie_dst != '0)
            else $error("stall on register zero");
    end
endmodule

// File: rtl/hzd_dual_fwd_unit.sv
// Module: hzd_dual_fwd_unit (top)
// Forwarding selects for both ALU operands and the load-use stall for a
// five-stage pipeline whose instructions may write two registers.
// Assumes: both destinations commit in writeback; the datapath uses the
// lane bit to pick the primary or secondary writeback value.
module hzd_dual_fwd_unit
    import hzd_pkg::*;
#(
    parameter int RW = 5
) (
    input  logic [RW-1:0] id_src_a,
    input  logic [RW-1:0] id_src_b,
    input  logic [RW-1:0] ex_src_a,
    input  logic [RW-1:0] ex_src_b,
    input  logic [RW-1:0] idex_dst_p,
    input  logic          idex_we_p,
    input  logic          idex_mrd,
    input  logic [RW-1:0] exmem_dst_p,
    input  logic          exmem_we_p,
    input  logic [RW-1:0] exmem_dst_s,
    input  logic          exmem_we_s,
    input  logic          exmem_mrd,
    input  logic [RW-1:0] memwb_dst_p,
    input  logic          memwb_we_p,
    input  logic [RW-1:0] memwb_dst_s,
    input  logic          memwb_we_s,
    output logic [1:0]    fwd_a_sel,
    output logic          fwd_a_lane,
    output logic [1:0]    fwd_b_sel,
    output logic          fwd_b_lane,
    output logic          stall_req,
    output logic          bubble_ins
);
    logic [NUM_OPS-1:0][RW-1:0] ex_src;
    fwd_src_e                   op_sel  [NUM_OPS];
    logic     [NUM_OPS-1:0]     op_lane;
    logic                       stall_w;

    // Gather execute-stage operand sources into an indexed vector.
    always_comb begin
        ex_src[0] = ex_src_a;
        ex_src[1] = ex_src_b;
    end

    // R11: one identical lane per ALU operand.
    for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
        hzd_fwd_lane #(.RW(RW)) u_lane (
            .src      (ex_src[g]),
            .xm_dst_p (exmem_dst_p),
            .xm_we_p  (exmem_we_p),
            .xm_dst_s (exmem_dst_s),
            .xm_we_s  (exmem_we_s),
            .xm_mrd   (exmem_mrd),
            .mw_dst_p (memwb_dst_p),
            .mw_we_p  (memwb_we_p),
            .mw_dst_s (memwb_dst_s),
            .mw_we_s  (memwb_we_s),
            .sel      (op_sel[g]),
            .lane     (op_lane[g])
        );
    end

    hzd_load_stall #(.RW(RW)) u_stall (
        .id_a   (id_src_a),
        .id_b   (id_src_b),
        .ie_dst (idex_dst_p),
        .ie_we  (idex_we_p),
        .ie_mrd (idex_mrd),
        .stall  (stall_w)
    );

    // Drive the output ports from the lane and stall results.
    always_comb begin
        fwd_a_sel  = op_sel[0];
        fwd_a_lane = op_lane[0];
        fwd_b_sel  = op_sel[1];
        fwd_b_lane = op_lane[1];
        stall_req  = stall_w;
        bubble_ins = stall_w;
    end
endmodule

// File: tb/hzd_dual_fwd_unit_tb_top.sv
// Bench: behavioural priority-scan model compared on every clock.
module hzd_dual_fwd_unit_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [4:0] id_src_a, id_src_b, ex_src_a, ex_src_b;
    logic [4:0] idex_dst_p, exmem_dst_p, exmem_dst_s, memwb_dst_p, memwb_dst_s;
    logic       idex_we_p, idex_mrd, exmem_we_p, exmem_we_s, exmem_mrd, memwb_we_p, memwb_we_s;
    logic [1:0] fwd_a_sel, fwd_b_sel;
    logic       fwd_a_lane, fwd_b_lane, stall_req, bubble_ins;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    hzd_dual_fwd_unit dut_i (
        .id_src_a(id_src_a), .id_src_b(id_src_b),
        .ex_src_a(ex_src_a), .ex_src_b(ex_src_b),
        .idex_dst_p(idex_dst_p), .idex_we_p(idex_we_p), .idex_mrd(idex_mrd),
        .exmem_dst_p(exmem_dst_p), .exmem_we_p(exmem_we_p),
        .exmem_dst_s(exmem_dst_s), .exmem_we_s(exmem_we_s), .exmem_mrd(exmem_mrd),
        .memwb_dst_p(memwb_dst_p), .memwb_we_p(memwb_we_p),
        .memwb_dst_s(memwb_dst_s), .memwb_we_s(memwb_we_s),
        .fwd_a_sel(fwd_a_sel), .fwd_a_lane(fwd_a_lane),
        .fwd_b_sel(fwd_b_sel), .fwd_b_lane(fwd_b_lane),
        .stall_req(stall_req), .bubble_ins(bubble_ins)
    );

    // Model: scan producers newest-first; result is {sel, lane}.
    function automatic logic [2:0] model_fwd(int src);
        int       who [4];
        bit       ok  [4];
        bit [2:0] res [4];
        who = '{int'(exmem_dst_s), int'(exmem_dst_p), int'(memwb_dst_p), int'(memwb_dst_s)};
        ok  = '{exmem_we_s && !(exmem_mrd && exmem_we_p && exmem_dst_p == exmem_dst_s),
                exmem_we_p && !exmem_mrd, memwb_we_p, memwb_we_s};
        res = '{3'b100, 3'b100, 3'b010, 3'b011};
        if (src == 0) return 3'b000;
        for (int i = 0; i < 4; i++)
            if (ok[i] && who[i] == src) return res[i];
        return 3'b000;
    endfunction

    function automatic bit model_stall();
        if (!(idex_mrd && idex_we_p) || idex_dst_p == 0) return 1'b0;
        return (idex_dst_p == id_src_a) || (idex_dst_p == id_src_b);
    endfunction

    task automatic idle();
        {id_src_a, id_src_b, ex_src_a, ex_src_b} = '0;
        {idex_dst_p, exmem_dst_p, exmem_dst_s, memwb_dst_p, memwb_dst_s} = '0;
        {idex_we_p, idex_mrd, exmem_we_p, exmem_we_s, exmem_mrd, memwb_we_p, memwb_we_s} = '0;
    endtask

    // Inputs were set at the falling edge; compare at the rising edge.
    task automatic check(string tag);
        logic [2:0] ea, eb;
        bit es, bad;
        @(posedge clk);
        ea = model_fwd(int'(ex_src_a));
        eb = model_fwd(int'(ex_src_b));
        es = model_stall();
        bad = 0;
        vectors++;
        if ({fwd_a_sel, fwd_a_lane} !== ea) begin
            $display("FAIL %s operand A: got %b expected %b", tag, {fwd_a_sel, fwd_a_lane}, ea); bad = 1;
        end
        if ({fwd_b_sel, fwd_b_lane} !== eb) begin
            $display("FAIL %s operand B (R11): got %b expected %b", tag, {fwd_b_sel, fwd_b_lane}, eb); bad = 1;
        end
        if (stall_req !== es || bubble_ins !== es) begin
            $display("FAIL %s stall/bubble (R7): got %b/%b expected %b", tag, stall_req, bubble_ins, es); bad = 1;
        end
        if (bad) miscompares++;
    endtask

    // Fixed-value check for directed cases, on top of the model compare.
    task automatic expect_ops(string tag, logic [2:0] ea, logic [2:0] eb, bit es);
        vectors++;
        if ({fwd_a_sel, fwd_a_lane} !== ea || {fwd_b_sel, fwd_b_lane} !== eb || stall_req !== es) begin
            $display("FAIL %s fixed: got %b/%b/%b expected %b/%b/%b", tag,
                     {fwd_a_sel, fwd_a_lane}, {fwd_b_sel, fwd_b_lane}, stall_req, ea, eb, es);
            miscompares++;
        end
    endtask

    initial begin
        idle();
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 idle");                       expect_ops("R9 idle", 3'b000, 3'b000, 0);

        // R2: ordinary result in execute/memory
        @(negedge clk); idle(); exmem_dst_p = 5; exmem_we_p = 1; ex_src_a = 5; ex_src_b = 9;
        check("R2 primary");                    expect_ops("R2 primary", 3'b100, 3'b000, 0);

        // R2 / R3: base-update load in execute/memory, primary 4, secondary 1
        @(negedge clk); idle(); exmem_dst_p = 4; exmem_we_p = 1; exmem_dst_s = 1; exmem_we_s = 1;
        exmem_mrd = 1; ex_src_a = 1; ex_src_b = 4;
        check("R2 R3 base");                    expect_ops("R2 R3 base", 3'b100, 3'b000, 0);

        // R3: primary equals base, load word is not in execute/memory yet
        @(negedge clk); idle(); exmem_dst_p = 3; exmem_we_p = 1; exmem_dst_s = 3; exmem_we_s = 1;
        exmem_mrd = 1; ex_src_a = 3;
        check("R3 same reg");                   expect_ops("R3 same reg", 3'b000, 3'b000, 0);

        // R4: both values from memory/writeback
        @(negedge clk); idle(); memwb_dst_p = 4; memwb_we_p = 1; memwb_dst_s = 1; memwb_we_s = 1;
        ex_src_a = 4; ex_src_b = 1;
        check("R4 lanes");                      expect_ops("R4 lanes", 3'b010, 3'b011, 0);

        // R5: primary wins over secondary for one register
        @(negedge clk); idle(); memwb_dst_p = 3; memwb_we_p = 1; memwb_dst_s = 3; memwb_we_s = 1;
        ex_src_a = 3; ex_src_b = 3;
        check("R5 primary wins");               expect_ops("R5 primary wins", 3'b010, 3'b010, 0);

        // R6: newer stage wins
        @(negedge clk); idle(); exmem_dst_p = 6; exmem_we_p = 1; memwb_dst_p = 6; memwb_we_p = 1;
        memwb_dst_s = 7; memwb_we_s = 1; ex_src_a = 6; ex_src_b = 7;
        check("R6 priority");                   expect_ops("R6 priority", 3'b100, 3'b011, 0);

        // R1: register zero everywhere
        @(negedge clk); idle(); exmem_we_p = 1; exmem_we_s = 1; memwb_we_p = 1; memwb_we_s = 1;
        idex_we_p = 1; idex_mrd = 1;
        check("R1 zero");                       expect_ops("R1 zero", 3'b000, 3'b000, 0);

        // R10: matching numbers with enables low
        @(negedge clk); idle(); exmem_dst_p = 8; exmem_dst_s = 8; memwb_dst_p = 9; memwb_dst_s = 9;
        idex_dst_p = 2; idex_mrd = 1; id_src_a = 2; ex_src_a = 8; ex_src_b = 9;
        check("R10 disabled");                  expect_ops("R10 disabled", 3'b000, 3'b000, 0);

        // R7: load-use on each decode source
        @(negedge clk); idle(); idex_dst_p = 4; idex_we_p = 1; idex_mrd = 1; id_src_b = 4; id_src_a = 5;
        check("R7 stall b");                    expect_ops("R7 stall b", 3'b000, 3'b000, 1);
        @(negedge clk); id_src_a = 4; id_src_b = 0;
        check("R7 stall a");                    expect_ops("R7 stall a", 3'b000, 3'b000, 1);

        // R8: non-load producer in decode/execute
        @(negedge clk); idex_mrd = 0;
        check("R8 no load");                    expect_ops("R8 no load", 3'b000, 3'b000, 0);

        // R2 R4 R6: base-update then add on base then sub on both results
        @(negedge clk); idle(); idex_dst_p = 4; idex_we_p = 1; idex_mrd = 1; id_src_a = 1; id_src_b = 7;
        check("R8 seq step1");                  expect_ops("R8 seq step1", 3'b000, 3'b000, 0);
        @(negedge clk); idle(); exmem_dst_p = 4; exmem_we_p = 1; exmem_dst_s = 1; exmem_we_s = 1;
        exmem_mrd = 1; ex_src_a = 1; ex_src_b = 7; idex_dst_p = 6; idex_we_p = 1; id_src_a = 6; id_src_b = 4;
        check("R2 seq step2");                  expect_ops("R2 seq step2", 3'b100, 3'b000, 0);
        @(negedge clk); idle(); memwb_dst_p = 4; memwb_we_p = 1; memwb_dst_s = 1; memwb_we_s = 1;
        exmem_dst_p = 6; exmem_we_p = 1; ex_src_a = 6; ex_src_b = 4;
        check("R4 R6 seq step3");               expect_ops("R4 R6 seq step3", 3'b100, 3'b010, 0);

        // Biased random pipeline states (R1..R11 via the model)
        for (int n = 0; n < 4000; n++) begin
            @(negedge clk);
            id_src_a = 5'($urandom_range(0, 7)); id_src_b = 5'($urandom_range(0, 7));
            ex_src_a = 5'($urandom_range(0, 7)); ex_src_b = 5'($urandom_range(0, 7));
            idex_dst_p  = 5'($urandom_range(0, 7)); exmem_dst_p = 5'($urandom_range(0, 7));
            exmem_dst_s = 5'($urandom_range(0, 7)); memwb_dst_p = 5'($urandom_range(0, 7));
            memwb_dst_s = 5'($urandom_range(0, 7));
            {idex_we_p, idex_mrd, exmem_we_p, exmem_we_s, exmem_mrd, memwb_we_p, memwb_we_s} = 7'($urandom);
            check("R11 random");
        end
        done = 1;
    end

    // Watchdog and final report.
    initial begin
        for (int c = 0; c < 200000 && !done; c++) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: run did not complete, got hang expected completion");
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule